// File: doc/BRIEF.md
# Periodic Down-Counter Timer

This block is a register-mapped interval timer for a processor subsystem. Software loads a period value, picks whether the count advances on every core clock or only on cycles where an external reference strobe is high, and turns the counter on. Each time the count runs out, a sticky status flag is set. An optional one-cycle interrupt pulse can also be raised. The counter then starts the next period on its own. A zero period value makes a one-shot: the counter turns itself off after the first expiry.

Access goes through a single-beat 32-bit request port. Every request gets a response one cycle later. Requests marked as unprivileged are refused with an error response and change nothing. Every access is a full 32-bit word, so the port carries no size field.

Top module: `period_timer`

## Requirements
- R1: After reset the control, period and current words all read 0, and `irq` is low.
- R2: Register offsets are 0x00 control, 0x04 period, 0x08 current and 0x0C calibration. In the control word, bit 0 is run, bit 1 is interrupt enable, bit 2 is source select and bit 16 is the expiry flag. Control writes change only bits 2:0. The period word reads back what was written. The calibration word always reads 10000.
- R3: Setting run from 0 to 1 with no count held loads the period value. One period lasts period+1 counting steps. With source select at 1 a step happens on every clock. With source select at 0 a step happens only on clocks where `ref_tick` is high.
- R4: An expiry (a step taken while the count is 0) sets the flag. If interrupt enable is 1, the expiry also drives `irq` high for exactly one cycle, starting on the same clock edge.
- R5: An expiry while the period value is 0 clears run, and the count is no longer held.
- R6: A control read returns the current contents and then clears the flag. An expiry on the same edge still leaves the flag set.
- R7: A write to the current word loads the period value into the counter, whatever the write data is. It also clears the flag, unless an expiry happens on the same edge.
- R8: The current word reads 0 while run is 0.
- R9: A request with `req_unpriv` high returns `rsp_err`=1 and `rsp_rdata`=0, and changes no state.
- R10: A read of any other offset returns 0 with no error. A write to any other offset has no effect.
- R11: Clearing run keeps the remaining count. Setting run again resumes from that count without reloading.
- R12: A control write that leaves run at 1 but changes the source select reloads the counter from the period value.
- R13: `rsp_valid` is high exactly one cycle after each request. `rsp_rdata` carries the register value from before that edge, and is 0 for writes and errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | Reference strobe; enables one count step when source select is 0 |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_unpriv | input | 1 | Request comes from unprivileged code |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_err | output | 1 | Request refused |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | One-cycle expiry interrupt pulse |

## Verification
The assertions assume that every input is a known value on every sampled edge. They also assume one request per cycle, so a single edge never carries two register writes. `ref_tick` may change freely from cycle to cycle. The bench drives all inputs on the falling edge, holds each request for exactly one cycle and runs `ref_tick` in a fixed irregular pattern. This exercises both source settings while keeping every request well-formed.

// File: rtl/ptmr_pkg.sv
// Package: shared constants for the periodic down-counter timer.
// Assumes byte offsets on a word-aligned 32-bit register port.
package ptmr_pkg;
    localparam int          DATA_W     = 32;
    localparam logic [7:0]  OFS_CTRL   = 8'h00;
    localparam logic [7:0]  OFS_PERIOD = 8'h04;
    localparam logic [7:0]  OFS_CUR    = 8'h08;
    localparam logic [7:0]  OFS_CAL    = 8'h0C;
    localparam int          B_RUN      = 0;
    localparam int          B_IEN      = 1;
    localparam int          B_SRC      = 2;
    localparam int          B_FLAG     = 16;
    localparam logic [31:0] CAL_WORD   = 32'd10000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PERIOD,
        SEL_CUR,
        SEL_CAL
    } reg_sel_e;
endpackage

// File: rtl/ptmr_bus.sv
// Module: ptmr_bus
// Decodes single-beat register requests into write/clear strobes and
// registers a response one cycle later. Unprivileged requests produce an
// error and no strobes. Assumes at most one request per cycle.
module ptmr_bus
    import ptmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_unpriv,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [DATA_W-1:0] period_word,
    input  logic [DATA_W-1:0] cur_word,
    output logic              wr_ctrl,
    output logic              wr_period,
    output logic              wr_cur,
    output logic              rd_ctrl,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    reg_sel_e          sel;
    logic              accept;
    logic [DATA_W-1:0] rd_mux;

    // Map the byte offset to a register select.
    always_comb begin
        if (req_addr == ADDR_W'(OFS_CTRL))        sel = SEL_CTRL;
        else if (req_addr == ADDR_W'(OFS_PERIOD)) sel = SEL_PERIOD;
        else if (req_addr == ADDR_W'(OFS_CUR))    sel = SEL_CUR;
        else if (req_addr == ADDR_W'(OFS_CAL))    sel = SEL_CAL;
        else                                      sel = SEL_NONE;
    end

    // Only privileged requests reach the register file.
    always_comb begin
        accept    = req_valid && !req_unpriv;
        wr_ctrl   = accept &&  req_write && (sel == SEL_CTRL);
        wr_period = accept &&  req_write && (sel == SEL_PERIOD);
        wr_cur    = accept &&  req_write && (sel == SEL_CUR);
        rd_ctrl   = accept && !req_write && (sel == SEL_CTRL);
    end

    // Select read data from the pre-edge register state.
    always_comb begin
        case (sel)
            SEL_CTRL:   rd_mux = ctrl_word;
            SEL_PERIOD: rd_mux = period_word;
            SEL_CUR:    rd_mux = cur_word;
            SEL_CAL:    rd_mux = CAL_WORD;
            default:    rd_mux = '0;
        endcase
    end

    // Register the response; data is zero except for accepted reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && req_unpriv;
            rsp_rdata <= (accept && !req_write) ? rd_mux : '0;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R13
    AST_ERR_ONLY_UNPRIV: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($past(req_unpriv) && rsp_rdata == '0)); // R9
    AST_CAL_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_unpriv && !req_write && sel == SEL_CAL)
            |=> (rsp_rdata == 32'd10000)); // R2
endmodule

// File: rtl/ptmr_core.sv
// Module: ptmr_core
// Holds the control bits, period value and down-counter. It steps the
// counter on each enabled tick, flags expiries and issues a one-cycle
// interrupt. Assumes at most one of the write strobes per cycle.
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_ctrl,
    input  logic              wr_period,
    input  logic              wr_cur,
    input  logic              rd_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] period_word,
    output logic [DATA_W-1:0] cur_word,
    output logic              irq
);
    logic             run_q, ien_q, src_q, flag_q, held_q;
    logic             run_d, ien_d, src_d, flag_d, held_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d;
    logic             step, expire;

    // A step is an enabled count event from the selected source.
    always_comb begin
        step   = run_q && (src_q || ref_tick);
        expire = step && (cnt_q == '0);
    end

    // Next state: counting first, then register writes take priority.
    always_comb begin
        run_d  = run_q;
        ien_d  = ien_q;
        src_d  = src_q;
        held_d = held_q;
        cnt_d  = cnt_q;
        per_d  = per_q;
        if (step) begin
            if (expire) begin
                if (per_q == '0) begin
                    run_d  = 1'b0;
                    held_d = 1'b0;
                    cnt_d  = '0;
                end else begin
                    cnt_d = per_q;
                end
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
        flag_d = (flag_q && !rd_ctrl && !wr_cur) || expire;
        if (wr_ctrl) begin
            run_d = wdata[B_RUN];
            ien_d = wdata[B_IEN];
            src_d = wdata[B_SRC];
            if (!run_q && wdata[B_RUN] && !held_q) begin
                cnt_d  = per_q;
                held_d = 1'b1;
            end else if (run_q && wdata[B_RUN] && (wdata[B_SRC] != src_q)) begin
                cnt_d  = per_q;
                held_d = 1'b1;
            end
        end
        if (wr_period) per_d = wdata[CNT_W-1:0];
        if (wr_cur) begin
            cnt_d  = per_q;
            held_d = 1'b1;
        end
    end

    // State registers and the registered interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            ien_q  <= 1'b0;
            src_q  <= 1'b0;
            flag_q <= 1'b0;
            held_q <= 1'b0;
            cnt_q  <= '0;
            per_q  <= '0;
            irq    <= 1'b0;
        end else begin
            run_q  <= run_d;
            ien_q  <= ien_d;
            src_q  <= src_d;
            flag_q <= flag_d;
            held_q <= held_d;
            cnt_q  <= cnt_d;
            per_q  <= per_d;
            irq    <= expire && ien_q;
        end
    end

    // Present the register words to the bus.
    always_comb begin
        ctrl_word         = '0;
        ctrl_word[B_RUN]  = run_q;
        ctrl_word[B_IEN]  = ien_q;
        ctrl_word[B_SRC]  = src_q;
        ctrl_word[B_FLAG] = flag_q;
        period_word       = DATA_W'(per_q);
        cur_word          = run_q ? DATA_W'(cnt_q) : '0;
    end

    AST_IRQ_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ien_q)); // R4
    AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q); // R4
    AST_ZERO_PERIOD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && per_q == '0 && !wr_ctrl) |=> !run_q); // R5
    AST_OFF_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_ctrl && !wr_cur) |=> $stable(cnt_q)); // R11
    AST_CUR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cur && !expire) |=> (!flag_q && cnt_q == $past(per_q))); // R7
endmodule

// File: rtl/period_timer.sv
// Module: period_timer (top)
// Periodic down-counter timer with a single-beat register port and a
// one-cycle interrupt. Assumes one request per cycle and a synchronous
// active-low reset.
module period_timer
    import ptmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_unpriv,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              irq
);
    logic              wr_ctrl, wr_period, wr_cur, rd_ctrl;
    logic [DATA_W-1:0] ctrl_word, period_word, cur_word;

    initial begin
        if (CNT_W > DATA_W || CNT_W < 1) $error("CNT_W out of range");
        if (ADDR_W < 4) $error("ADDR_W too small");
    end

    ptmr_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_unpriv (req_unpriv),
        .req_addr   (req_addr),
        .ctrl_word  (ctrl_word),
        .period_word(period_word),
        .cur_word   (cur_word),
        .wr_ctrl    (wr_ctrl),
        .wr_period  (wr_period),
        .wr_cur     (wr_cur),
        .rd_ctrl    (rd_ctrl),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata)
    );

    ptmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .wr_ctrl    (wr_ctrl),
        .wr_period  (wr_period),
        .wr_cur     (wr_cur),
        .rd_ctrl    (rd_ctrl),
        .wdata      (req_wdata),
        .ctrl_word  (ctrl_word),
        .period_word(period_word),
        .cur_word   (cur_word),
        .irq        (irq)
    );

    AST_UNPRIV_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_unpriv) |=> ($stable(period_word) && $stable(ctrl_word[2:0]))); // R9
endmodule

// File: tb/sim_period_timer.sv
`timescale 1ns/1ps
module sim_period_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_unpriv = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, irq;
    logic [31:0] rsp_rdata;

    int    checks = 0;
    int    failures = 0;
    string tag = "R1";
    bit    started = 0;
    bit    done = 0;

    // Reference model state
    bit          m_run, m_ien, m_src, m_flag, m_held;
    logic [31:0] m_cnt, m_per;
    bit          e_valid, e_err, e_irq;
    logic [31:0] e_rdata;

    always #10 clk = ~clk;

    period_timer u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .req_valid(req_valid), .req_write(req_write), .req_unpriv(req_unpriv),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic check(string t, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // Behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_run = 0; m_ien = 0; m_src = 0; m_flag = 0; m_held = 0;
            m_cnt = 0; m_per = 0;
            e_valid = 0; e_err = 0; e_irq = 0; e_rdata = 0;
        end else begin
            bit acc, wc, wp, wcur, rc, ex, tk;
            bit n_run, n_held;
            logic [31:0] n_cnt;
            acc  = req_valid && !req_unpriv;
            wc   = acc && req_write && req_addr == 8'h00;
            wp   = acc && req_write && req_addr == 8'h04;
            wcur = acc && req_write && req_addr == 8'h08;
            rc   = acc && !req_write && req_addr == 8'h00;
            e_valid = req_valid;
            e_err   = req_valid && req_unpriv;
            e_rdata = 0;
            if (acc && !req_write) begin
                if (req_addr == 8'h00) e_rdata = {15'd0, m_flag, 13'd0, m_src, m_ien, m_run};
                else if (req_addr == 8'h04) e_rdata = m_per;
                else if (req_addr == 8'h08) e_rdata = m_run ? m_cnt : 0;
                else if (req_addr == 8'h0C) e_rdata = 10000;
            end
            tk = m_run && (m_src || ref_tick);
            ex = 0; n_run = m_run; n_held = m_held; n_cnt = m_cnt;
            if (tk) begin
                if (m_cnt == 0) begin
                    ex = 1;
                    if (m_per == 0) begin n_run = 0; n_held = 0; n_cnt = 0; end
                    else n_cnt = m_per;
                end else n_cnt = m_cnt - 1;
            end
            e_irq = ex && m_ien;
            m_flag = (m_flag && !rc && !wcur) || ex;
            if (wc) begin
                if ((!m_run && req_wdata[0] && !m_held) ||
                    (m_run && req_wdata[0] && req_wdata[2] != m_src)) begin
                    n_cnt = m_per; n_held = 1;
                end
                n_run = req_wdata[0]; m_ien = req_wdata[1]; m_src = req_wdata[2];
            end
            if (wcur) begin n_cnt = m_per; n_held = 1; end
            if (wp) m_per = req_wdata;
            m_run = n_run; m_held = n_held; m_cnt = n_cnt;
        end
    end

    // Compare the design against the model away from the rising edge
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (rsp_valid !== e_valid || rsp_err !== e_err ||
                rsp_rdata !== e_rdata || irq !== e_irq) begin
                failures++;
                $display("FAIL %s actual=v%b e%b d%h i%b expected=v%b e%b d%h i%b", tag,
                         rsp_valid, rsp_err, rsp_rdata, irq, e_valid, e_err, e_rdata, e_irq);
            end
        end
    end

    // Irregular reference strobe pattern
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        ref_tick <= (cyc % 3 == 0) || (cyc % 7 == 2);
    end

    task automatic bus(input bit wr, input bit up, input logic [7:0] a,
                       input logic [31:0] d, output logic [31:0] rd, output bit er);
        req_valid = 1; req_write = wr; req_unpriv = up; req_addr = a; req_wdata = d;
        @(negedge clk);
        rd = rsp_rdata; er = rsp_err;
        req_valid = 0; req_write = 0; req_unpriv = 0; req_wdata = 0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < 200);
    endtask

    task automatic summary();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [31:0] rd;
        bit er;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R1";
        check("R1 irq", {31'd0, irq}, 0);
        bus(0, 0, 8'h00, 0, rd, er); check("R1 ctrl", rd, 0);
        bus(0, 0, 8'h04, 0, rd, er); check("R1 period", rd, 0);
        bus(0, 0, 8'h08, 0, rd, er); check("R1 cur", rd, 0);

        tag = "R2";
        bus(0, 0, 8'h0C, 0, rd, er); check("R2 cal", rd, 10000);
        bus(1, 0, 8'h00, 32'hFFFF_FFF8, rd, er);
        bus(0, 0, 8'h00, 0, rd, er); check("R2 ctrl mask", rd, 0);
        bus(1, 0, 8'h04, 32'hA5A5_5A5A, rd, er);
        bus(0, 0, 8'h04, 0, rd, er); check("R2 period rb", rd, 32'hA5A5_5A5A);
        bus(1, 0, 8'h04, 4, rd, er);

        tag = "R3";
        bus(1, 0, 8'h00, 7, rd, er);
        wait_irq(n); check("R3 period len", n, 5);
        tag = "R6";
        bus(0, 0, 8'h00, 0, rd, er); check("R4 flag set", rd, 32'h0001_0007);
        check("R4 irq one cycle", {31'd0, irq}, 0);
        bus(0, 0, 8'h00, 0, rd, er); check("R6 flag cleared", rd, 7);

        tag = "R9";
        bus(1, 1, 8'h04, 99, rd, er); check("R9 err", {31'd0, er}, 1);
        bus(0, 1, 8'h00, 0, rd, er); check("R9 rd zero", rd, 0);
        bus(0, 0, 8'h04, 0, rd, er); check("R9 period kept", rd, 4);
        tag = "R10";
        bus(0, 0, 8'h10, 0, rd, er); check("R10 undecoded", rd, 0);
        check("R10 no err", {31'd0, er}, 0);
        bus(1, 0, 8'h14, 32'hFFFF_FFFF, rd, er);

        tag = "R7";
        wait_irq(n);
        bus(1, 0, 8'h08, 32'h1234, rd, er);
        bus(0, 0, 8'h00, 0, rd, er); check("R7 flag clr", rd, 7);
        bus(0, 0, 8'h08, 0, rd, er); check("R7 reload", rd, 3);
        tag = "R8";
        bus(1, 0, 8'h00, 6, rd, er);
        bus(0, 0, 8'h08, 0, rd, er); check("R8 cur off", rd, 0);
        tag = "R11";
        bus(1, 0, 8'h00, 7, rd, er);
        wait_irq(n); check("R11 resume", n, 2);
        tag = "R12";
        bus(1, 0, 8'h00, 3, rd, er);
        bus(0, 0, 8'h08, 0, rd, er); check("R12 src reload", rd, 4);
        tag = "R3";
        repeat (40) @(negedge clk);

        tag = "R5";
        bus(1, 0, 8'h00, 0, rd, er);
        bus(1, 0, 8'h04, 0, rd, er);
        bus(1, 0, 8'h08, 0, rd, er);
        bus(1, 0, 8'h00, 5, rd, er);
        @(negedge clk);
        check("R5 no irq", {31'd0, irq}, 0);
        bus(0, 0, 8'h00, 0, rd, er); check("R5 stopped", rd, 32'h0001_0004);
        bus(1, 0, 8'h04, 2, rd, er);
        bus(1, 0, 8'h00, 7, rd, er);
        tag = "R13";
        repeat (20) @(negedge clk);
        summary();
    end
endmodule